// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside the storage array of a dual-clock FIFO. It holds two threshold registers, one for the almost-empty flag and one for the almost-full flag, and drives both flags from the FIFO's binary write and read pointers. During master reset a small set of strap inputs is captured. These straps fix the default thresholds, the way the thresholds may later be loaded (a bit-serial stream or whole parallel words), the bit layout of the parallel word (with or without a parity bit in every byte lane), and the clocking of the flags.

After reset, driving the load input low opens the threshold registers. Write-clock strobes load them, in serial or in parallel, and read-clock strobes return their contents on a read-back bus. While the load input is low, the two gate outputs tell the surrounding FIFO that ordinary data writes and reads must not proceed. The read-back bus is a plain output stream with a one-cycle valid pulse for each read strobe. It has no ready input and cannot be back-pressured: the consumer must take every word in the cycle it is marked valid.

Top module: `almost_flag_unit`

## Requirements
- R1: During master reset (mrst_n low, sampled on each clock), the 3-bit index k = {load_n, dsel[1], dsel[0]} selects the default for both thresholds: (2^(k+3))-1, that is 7, 15, 31 ... 1023, truncated to the threshold width.
- R2: The method is fixed at reset. load_n low during reset selects serial loading. load_n high during reset selects parallel loading.
- R3: In parallel mode, each write-clock edge with load_n and wen_n both low loads one threshold from pdin. The first such edge after load_n falls loads almost-empty, the next loads almost-full, and the two alternate after that. The alternation restarts at almost-empty whenever load_n is high.
- R4: In serial mode, each write-clock edge with load_n and wen_n both low shifts sdin in. The almost-empty threshold comes first and the almost-full threshold follows, each least significant bit first, 2×(AW+1) bits in total.
- R5: Only the strapped method changes the thresholds. pdin is ignored in serial mode and sdin is ignored in parallel mode. With load_n high, wen_n has no effect on the thresholds.
- R6: With par_intersp high at reset, pdin bits 8, 17, 26 and 35 are parity and are skipped. The threshold is the low AW+1 bits of {pdin[34:27], pdin[25:18], pdin[16:9], pdin[7:0]}. With par_intersp low, the threshold is the low AW+1 bits of pdin[31:0], and pdin[35:32] is ignored.
- R7: A read-clock edge with load_n and ren_n both low makes rb_valid high for the following read-clock cycle. rb_data then holds a threshold in the same layout as R6, with the parity or unused bits and all payload bits above the threshold zero. Almost-empty is returned first, then almost-full, alternating and restarting whenever load_n is high. Read-back is available in both methods.
- R8: wr_allow and rd_allow are low during master reset and whenever load_n is low. Otherwise they are high.
- R9: Once the pointers are steady, ae_n is low exactly when (wptr − rptr) mod 2^(AW+1) ≤ the almost-empty threshold. af_n is low exactly when 2^AW − (wptr − rptr) ≤ the almost-full threshold.
- R10: With pfm_sync high at reset, ae_n changes only on read-clock edges (it uses a synchronised write pointer) and af_n only on write-clock edges. With pfm_sync low, both flags follow the raw pointers directly: a move of rptr or wptr changes the flag without waiting for any clock edge. After reset with pointers at zero, ae_n is low and af_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| load_n | input | 1 | Strap during reset; threshold access enable (active low) afterwards |
| dsel | input | 2 | Default-threshold select strap |
| pfm_sync | input | 1 | Flag clocking strap: 1 = single-clock per flag, 0 = pointer-direct |
| par_intersp | input | 1 | Parallel word layout strap: 1 = parity in every byte lane |
| wen_n | input | 1 | Write strobe, active low |
| ren_n | input | 1 | Read strobe, active low |
| pdin | input | 36 | Parallel threshold word |
| sdin | input | 1 | Serial threshold bit |
| wptr | input | AW+1 | FIFO write pointer, binary, write domain |
| rptr | input | AW+1 | FIFO read pointer, binary, read domain |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| rb_data | output | 36 | Threshold read-back word |
| rb_valid | output | 1 | Read-back word valid for one read-clock cycle |
| wr_allow | output | 1 | FIFO data writes permitted |
| rd_allow | output | 1 | FIFO data reads permitted |

## Verification
Every one of the eight strap codes is applied and its default pair is read back. This separates the index ordering from the power-of-two formula. Parallel words are written in both layouts, with ones planted in the parity or unused positions and in payload bits above the threshold, so an extraction that uses the wrong bit lanes shows up in the read-back. A serial stream with distinct bit patterns for each threshold exposes errors in bit order and in which threshold is filled first. The flags are swept over every occupancy from empty to full, with the pointers wrapping, in both clocking modes. A pointer step placed just after a clock edge then shows whether the flag reacts at once or only at the next edge of its own clock.

// File: rtl/afo_pkg.sv
package afo_pkg;

  typedef enum logic {
    LOAD_SERIAL   = 1'b0,
    LOAD_PARALLEL = 1'b1
  } load_method_e;

  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } slot_e;

  localparam int WORD_W = 36;
  localparam int PAYLOAD_W = 32;

  // Compact a 36-bit parallel word into its 32 payload bits.
  function automatic logic [PAYLOAD_W-1:0] pack_payload(input logic [WORD_W-1:0] w,
                                                        input logic intersp);
    if (intersp) return {w[34:27], w[25:18], w[16:9], w[7:0]};
    else         return w[31:0];
  endfunction

  // Spread 32 payload bits back into a 36-bit word, parity or spare bits zero.
  function automatic logic [WORD_W-1:0] unpack_payload(input logic [PAYLOAD_W-1:0] v,
                                                       input logic intersp);
    if (intersp) return {1'b0, v[31:24], 1'b0, v[23:16], 1'b0, v[15:8], 1'b0, v[7:0]};
    else         return {4'b0000, v};
  endfunction

endpackage

// File: rtl/afo_offset_bank.sv
module afo_offset_bank
  import afo_pkg::*;
#(
  parameter int OW = 11
) (
  input  logic              wclk,
  input  logic              mrst_n,
  input  logic              load_n,
  input  logic [1:0]        dsel,
  input  logic              intersp_strap,
  input  logic              wen_n,
  input  logic [WORD_W-1:0] pdin,
  input  logic              sdin,
  output logic [OW-1:0]     ae_off,
  output logic [OW-1:0]     af_off,
  output logic              par_mode,
  output logic              wr_allow
);

  load_method_e method_q;
  slot_e        slot_q;
  logic         intersp_q;
  logic         run_q;
  logic [2:0]   dflt_idx;
  logic [OW-1:0] dflt_val;
  logic [OW-1:0] par_val;
  logic [2*OW-1:0] chain_next;

  assign dflt_idx   = {load_n, dsel};
  assign dflt_val   = OW'((32'd1 << ({29'd0, dflt_idx} + 32'd3)) - 32'd1);
  assign par_val    = OW'(pack_payload(pdin, intersp_q));
  assign chain_next = {sdin, af_off, ae_off[OW-1:1]};

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      method_q  <= load_n ? LOAD_PARALLEL : LOAD_SERIAL;
      intersp_q <= intersp_strap;
      ae_off    <= dflt_val;
      af_off    <= dflt_val;
      slot_q    <= SLOT_AE;
      run_q     <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load_n) begin
        slot_q <= SLOT_AE;
      end else if (!wen_n) begin
        if (method_q == LOAD_PARALLEL) begin
          if (slot_q == SLOT_AE) ae_off <= par_val;
          else                   af_off <= par_val;
          slot_q <= (slot_q == SLOT_AE) ? SLOT_AF : SLOT_AE;
        end else begin
          ae_off <= chain_next[OW-1:0];
          af_off <= chain_next[2*OW-1:OW];
        end
      end
    end
  end

  assign par_mode = (method_q == LOAD_PARALLEL);
  assign wr_allow = run_q & load_n;

endmodule

// File: rtl/afo_readback.sv
module afo_readback
  import afo_pkg::*;
#(
  parameter int OW = 11
) (
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              load_n,
  input  logic              ren_n,
  input  logic              intersp_strap,
  input  logic [OW-1:0]     ae_off,
  input  logic [OW-1:0]     af_off,
  output logic [WORD_W-1:0] rb_data,
  output logic              rb_valid,
  output logic              rd_allow
);

  slot_e rslot_q;
  logic  intersp_q;
  logic  run_q;
  logic [OW-1:0] pick;

  assign pick = (rslot_q == SLOT_AE) ? ae_off : af_off;

  always_ff @(posedge rclk) begin
    if (!mrst_n) begin
      intersp_q <= intersp_strap;
      rslot_q   <= SLOT_AE;
      rb_data   <= '0;
      rb_valid  <= 1'b0;
      run_q     <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      rb_valid <= 1'b0;
      if (load_n) begin
        rslot_q <= SLOT_AE;
      end else if (!ren_n) begin
        rb_data  <= unpack_payload(32'(pick), intersp_q);
        rb_valid <= 1'b1;
        rslot_q  <= (rslot_q == SLOT_AE) ? SLOT_AF : SLOT_AE;
      end
    end
  end

  assign rd_allow = run_q & load_n;

endmodule

// File: rtl/afo_ptr_sync.sv
module afo_ptr_sync #(
  parameter int W = 11
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         mrst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);

  logic [W-1:0] src_gray;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge src_clk) begin
    if (!mrst_n) src_gray <= '0;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (!mrst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ sync_q[i];
      dst_bin[i] = acc;
    end
  end

endmodule

// File: rtl/afo_flag_core.sv
module afo_flag_core #(
  parameter int AW        = 10,
  parameter bit FULL_SIDE = 1'b0
) (
  input  logic        clk,
  input  logic        mrst_n,
  input  logic        mode_strap,
  input  logic [AW:0] own_ptr,
  input  logic [AW:0] far_sync,
  input  logic [AW:0] far_raw,
  input  logic [AW:0] offset,
  output logic        flag_n
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];
  localparam logic RST_FLAG = FULL_SIDE ? 1'b1 : 1'b0;

  logic [AW:0] lvl_sync;
  logic [AW:0] lvl_raw;
  logic        mode_q;
  logic        flag_q;

  generate
    if (FULL_SIDE) begin : g_free
      assign lvl_sync = DEPTH_V - (own_ptr - far_sync);
      assign lvl_raw  = DEPTH_V - (own_ptr - far_raw);
    end else begin : g_fill
      assign lvl_sync = far_sync - own_ptr;
      assign lvl_raw  = far_raw - own_ptr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q <= mode_strap;
      flag_q <= RST_FLAG;
    end else begin
      flag_q <= !(lvl_sync <= offset);
    end
  end

  assign flag_n = mode_q ? flag_q : !(lvl_raw <= offset);

endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
  import afo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        mrst_n,
  input  logic        load_n,
  input  logic [1:0]  dsel,
  input  logic        pfm_sync,
  input  logic        par_intersp,
  input  logic        wen_n,
  input  logic        ren_n,
  input  logic [35:0] pdin,
  input  logic        sdin,
  input  logic [AW:0] wptr,
  input  logic [AW:0] rptr,
  output logic        ae_n,
  output logic        af_n,
  output logic [35:0] rb_data,
  output logic        rb_valid,
  output logic        wr_allow,
  output logic        rd_allow
);

  localparam int OW = AW + 1;

  logic [OW-1:0] ae_off;
  logic [OW-1:0] af_off;
  logic          par_mode;
  logic [AW:0]   wptr_at_r;
  logic [AW:0]   rptr_at_w;

  afo_offset_bank #(.OW(OW)) u_bank (
    .wclk(wclk), .mrst_n(mrst_n), .load_n(load_n), .dsel(dsel),
    .intersp_strap(par_intersp), .wen_n(wen_n), .pdin(pdin), .sdin(sdin),
    .ae_off(ae_off), .af_off(af_off), .par_mode(par_mode), .wr_allow(wr_allow)
  );

  afo_readback #(.OW(OW)) u_rb (
    .rclk(rclk), .mrst_n(mrst_n), .load_n(load_n), .ren_n(ren_n),
    .intersp_strap(par_intersp), .ae_off(ae_off), .af_off(af_off),
    .rb_data(rb_data), .rb_valid(rb_valid), .rd_allow(rd_allow)
  );

  afo_ptr_sync #(.W(AW + 1)) u_wsync (
    .src_clk(wclk), .dst_clk(rclk), .mrst_n(mrst_n),
    .src_bin(wptr), .dst_bin(wptr_at_r)
  );

  afo_ptr_sync #(.W(AW + 1)) u_rsync (
    .src_clk(rclk), .dst_clk(wclk), .mrst_n(mrst_n),
    .src_bin(rptr), .dst_bin(rptr_at_w)
  );

  afo_flag_core #(.AW(AW), .FULL_SIDE(1'b0)) u_ae (
    .clk(rclk), .mrst_n(mrst_n), .mode_strap(pfm_sync),
    .own_ptr(rptr), .far_sync(wptr_at_r), .far_raw(wptr),
    .offset(ae_off), .flag_n(ae_n)
  );

  afo_flag_core #(.AW(AW), .FULL_SIDE(1'b1)) u_af (
    .clk(wclk), .mrst_n(mrst_n), .mode_strap(pfm_sync),
    .own_ptr(wptr), .far_sync(rptr_at_w), .far_raw(rptr),
    .offset(af_off), .flag_n(af_n)
  );

endmodule

// File: rtl/almost_flag_unit_chk.sv
module almost_flag_unit_chk #(
  parameter int OW = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          load_n,
  input logic          wen_n,
  input logic          ren_n,
  input logic          sdin,
  input logic          par_mode,
  input logic [OW-1:0] ae_off,
  input logic [OW-1:0] af_off,
  input logic          rb_valid
);

  // R4: a serial strobe moves sdin into the top of almost-full, and almost-full's LSB into almost-empty
  p_serial_chain_r4: assert property (@(posedge wclk) disable iff (!mrst_n)
    (!par_mode && !load_n && !wen_n) |=>
      (af_off[OW-1] == $past(sdin)) && (ae_off[OW-1] == $past(af_off[0])));

  // R5: thresholds cannot move without an active load strobe
  p_idle_hold_r5: assert property (@(posedge wclk) disable iff (!mrst_n)
    (load_n || wen_n) |=> ($stable(ae_off) && $stable(af_off)));

  // R7: every read-back strobe yields a valid word one cycle later
  p_rb_fire_r7: assert property (@(posedge rclk) disable iff (!mrst_n)
    (!load_n && !ren_n) |=> rb_valid);

  // R7: no valid word appears without a strobe
  p_rb_quiet_r7: assert property (@(posedge rclk) disable iff (!mrst_n)
    (load_n || ren_n) |=> !rb_valid);

endmodule

bind almost_flag_unit almost_flag_unit_chk #(.OW(OW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .load_n(load_n),
  .wen_n(wen_n), .ren_n(ren_n), .sdin(sdin), .par_mode(par_mode),
  .ae_off(ae_off), .af_off(af_off), .rb_valid(rb_valid)
);

// File: tb/almost_flag_unit_test.sv
module almost_flag_unit_test;

  localparam int AW = 10;
  localparam int OW = 11;
  localparam int DEPTH = 1024;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic mrst_n = 1'b0;
  logic load_n = 1'b1;
  logic [1:0] dsel = 2'b00;
  logic pfm_sync = 1'b1;
  logic par_intersp = 1'b0;
  logic wen_n = 1'b1;
  logic ren_n = 1'b1;
  logic [35:0] pdin = '0;
  logic sdin = 1'b0;
  logic [AW:0] wptr = '0;
  logic [AW:0] rptr = '0;
  logic ae_n, af_n, rb_valid, wr_allow, rd_allow;
  logic [35:0] rb_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 wclk = ~wclk;
  initial begin
    #2;
    forever #5 rclk = ~rclk;
  end

  almost_flag_unit uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .load_n(load_n), .dsel(dsel),
    .pfm_sync(pfm_sync), .par_intersp(par_intersp), .wen_n(wen_n), .ren_n(ren_n),
    .pdin(pdin), .sdin(sdin), .wptr(wptr), .rptr(rptr), .ae_n(ae_n), .af_n(af_n),
    .rb_data(rb_data), .rb_valid(rb_valid), .wr_allow(wr_allow), .rd_allow(rd_allow)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] lay(input logic ip, input logic [31:0] p, input logic [3:0] fill);
    if (ip) return {fill[3], p[31:24], fill[2], p[23:16], fill[1], p[15:8], fill[0], p[7:0]};
    else    return {fill, p};
  endfunction

  function automatic logic [35:0] wr_word(input logic ip, input logic [OW-1:0] v);
    return lay(ip, {21'h15A5A5, v}, 4'hF);
  endfunction

  function automatic logic [35:0] rb_word(input logic ip, input logic [OW-1:0] v);
    return lay(ip, {21'h0, v}, 4'h0);
  endfunction

  task automatic do_reset(input logic ld, input logic [1:0] ds, input logic pfm, input logic ip);
    @(negedge wclk);
    mrst_n = 1'b0; load_n = ld; dsel = ds; pfm_sync = pfm; par_intersp = ip;
    wen_n = 1'b1; ren_n = 1'b1; wptr = '0; rptr = '0;
    repeat (4) @(negedge wclk);
    chk("R8 wr_allow in reset", {35'd0, wr_allow}, 36'd0);
    chk("R8 rd_allow in reset", {35'd0, rd_allow}, 36'd0);
    mrst_n = 1'b1;
    @(negedge wclk);
    load_n = 1'b1;
    repeat (3) @(negedge wclk);
  endtask

  task automatic read_pair(input string tag, input logic [35:0] e0, input logic [35:0] e1);
    @(negedge rclk);
    load_n = 1'b0; ren_n = 1'b0;
    @(negedge rclk);
    chk({tag, " R7 valid first"}, {35'd0, rb_valid}, 36'd1);
    chk({tag, " R7 almost-empty word"}, rb_data, e0);
    chk({tag, " R8 wr_allow while loading"}, {35'd0, wr_allow}, 36'd0);
    chk({tag, " R8 rd_allow while loading"}, {35'd0, rd_allow}, 36'd0);
    @(negedge rclk);
    ren_n = 1'b1;
    chk({tag, " R7 valid second"}, {35'd0, rb_valid}, 36'd1);
    chk({tag, " R7 almost-full word"}, rb_data, e1);
    @(negedge rclk);
    chk({tag, " R7 valid drops"}, {35'd0, rb_valid}, 36'd0);
    load_n = 1'b1;
    @(negedge rclk);
    chk({tag, " R8 allow restored"}, {34'd0, wr_allow, rd_allow}, 36'd3);
  endtask

  task automatic par_write(input logic [35:0] w0, input logic [35:0] w1);
    @(negedge wclk);
    load_n = 1'b0; wen_n = 1'b0; pdin = w0; sdin = 1'b1;
    @(negedge wclk);
    pdin = w1; sdin = 1'b0;
    @(negedge wclk);
    wen_n = 1'b1; load_n = 1'b1;
    @(negedge wclk);
  endtask

  task automatic ser_load(input logic [OW-1:0] a, input logic [OW-1:0] b);
    @(negedge wclk);
    load_n = 1'b0; wen_n = 1'b0;
    for (int i = 0; i < 2 * OW; i++) begin
      sdin = (i < OW) ? a[i] : b[i - OW];
      pdin = {4'hF, 32'(i * 32'h01010101)};
      @(negedge wclk);
    end
    wen_n = 1'b1; load_n = 1'b1;
    @(negedge wclk);
  endtask

  task automatic sweep(input string tag, input logic sync_mode,
                       input int ae_t, input int af_t);
    for (int occ = 0; occ <= DEPTH; occ++) begin
      @(negedge wclk);
      if (sync_mode) begin
        wptr = 11'(900 + occ); rptr = 11'(900);
        repeat (6) @(negedge wclk);
      end else begin
        wptr = 11'(300); rptr = 11'(300 - occ);
        #1;
      end
      chk({tag, " R9 ae_n"}, {35'd0, ae_n}, {35'd0, !(occ <= ae_t)});
      chk({tag, " R9 af_n"}, {35'd0, af_n}, {35'd0, !((DEPTH - occ) <= af_t)});
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 / R2: every strap code, defaults read back
    for (int k = 0; k < 8; k++) begin
      logic [OW-1:0] d;
      d = OW'((1 << (k + 3)) - 1);
      do_reset(k[2], k[1:0], 1'b1, 1'b0);
      chk("R10 ae_n after reset", {35'd0, ae_n}, 36'd0);
      chk("R10 af_n after reset", {35'd0, af_n}, 36'd1);
      read_pair("R1 default", rb_word(1'b0, d), rb_word(1'b0, d));
    end

    // R3 / R6: parallel, plain layout
    do_reset(1'b1, 2'b00, 1'b1, 1'b0);
    par_write(wr_word(1'b0, 11'h3C5), wr_word(1'b0, 11'h0A6));
    read_pair("R3 R6 plain", rb_word(1'b0, 11'h3C5), rb_word(1'b0, 11'h0A6));

    // R5: strobes with load_n high leave thresholds alone
    @(negedge wclk);
    wen_n = 1'b0; pdin = wr_word(1'b0, 11'h111); sdin = 1'b1;
    repeat (3) @(negedge wclk);
    wen_n = 1'b1;
    read_pair("R5 no load", rb_word(1'b0, 11'h3C5), rb_word(1'b0, 11'h0A6));

    // R6: parallel, interspersed parity layout
    do_reset(1'b1, 2'b01, 1'b1, 1'b1);
    par_write(wr_word(1'b1, 11'h5A3), wr_word(1'b1, 11'h1FF));
    read_pair("R6 parity", rb_word(1'b1, 11'h5A3), rb_word(1'b1, 11'h1FF));

    // R4 / R5: serial load, pdin churning
    do_reset(1'b0, 2'b11, 1'b1, 1'b0);
    ser_load(11'h2C7, 11'h4B1);
    read_pair("R4 serial", rb_word(1'b0, 11'h2C7), rb_word(1'b0, 11'h4B1));

    // R9: single-clock flags across all occupancies
    do_reset(1'b1, 2'b00, 1'b1, 1'b0);
    par_write(wr_word(1'b0, 11'd100), wr_word(1'b0, 11'd200));
    sweep("sync", 1'b1, 100, 200);

    // R10: single-clock mode waits for its own edge
    @(negedge wclk);
    wptr = 11'(900 + 101); rptr = 11'(900);
    repeat (8) @(negedge wclk);
    chk("R10 sync ae_n before step", {35'd0, ae_n}, 36'd1);
    @(posedge rclk);
    #1 rptr = 11'(901);
    #2 chk("R10 sync ae_n held until edge", {35'd0, ae_n}, 36'd1);
    repeat (2) @(negedge rclk);
    chk("R10 sync ae_n after edge", {35'd0, ae_n}, 36'd0);

    // R9 / R10: pointer-direct flags
    do_reset(1'b1, 2'b00, 1'b0, 1'b0);
    par_write(wr_word(1'b0, 11'd0), wr_word(1'b0, 11'd1023));
    sweep("direct", 1'b0, 0, 1023);
    @(negedge wclk);
    wptr = 11'(40); rptr = 11'(39);
    #1 chk("R10 direct ae_n before step", {35'd0, ae_n}, 36'd1);
    @(posedge rclk);
    #1 rptr = 11'(40);
    #2 chk("R10 direct ae_n at once", {35'd0, ae_n}, 36'd0);
    @(posedge wclk);
    #1 wptr = 11'(41);
    #2 chk("R10 direct ae_n clears at once", {35'd0, ae_n}, 36'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule